// File: doc/BRIEF.md
# Accumulator ALU with Register Pair

This block is the arithmetic core of a small 4-bit processor. It holds two registers. The accumulator (A) is the destination of every arithmetic and logic operation. The auxiliary register (B) supplies the second operand. A source selector picks what is written into A: an immediate operand, a word read from data memory, the contents of B, or the result of the arithmetic unit.

The surrounding controller presents a 4-bit opcode together with the immediate and memory-data words, then pulses a write strobe. On that clock edge the block applies exactly one transfer or operation. Both register values are exported continuously. A flag that is true while A equals B is also exported, so a conditional jump can test it directly.

Top module: `acc_regpair_alu`

## Requirements
- R1: When `rst` is high at a clock edge, A and B both become 0 at that edge; the reset is synchronous.
- R2: When `wr_en` is low at a clock edge, A and B keep their values, whatever the opcode is.
- R3: Opcode 0000 with `wr_en` copies A into B; A is unchanged.
- R4: Opcode 0001 with `wr_en` copies B into A; B is unchanged.
- R5: Opcode 0010 loads `imm_val` into A, and opcode 0011 loads `mem_rd` into A; B is unchanged in both cases.
- R6: Opcode 1101 writes A+B into A, and opcode 1100 writes A-B into A; both wrap modulo 2^W.
- R7: Opcode 1010 writes A AND B into A, and opcode 1011 writes A OR B into A.
- R8: Opcode 1111 writes A+1 into A, and opcode 1110 writes A-1 into A; both wrap, so F+1 gives 0 and 0-1 gives F.
- R9: Opcode 1000 shifts A left by one bit, and opcode 1001 shifts A right by one bit; the vacated bit is filled with 0.
- R10: Opcodes 0100, 0101, 0110 and 0111 leave A and B unchanged even when `wr_en` is high.
- R11: `acc_eq_aux` is 1 exactly when A and B hold equal values. It follows the registers, so it shows the effect of a write in the cycle after that write.
- R12: Every opcode other than 0000 leaves B unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all registers update on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_code | input | 4 | Operation selector |
| imm_val | input | W (4) | Immediate operand for the immediate load |
| mem_rd | input | W (4) | Data-memory word for the memory load |
| wr_en | input | 1 | Write strobe; the operation takes effect only when it is high |
| acc_q | output | W (4) | Current accumulator value |
| aux_q | output | W (4) | Current auxiliary register value |
| acc_eq_aux | output | 1 | High while accumulator and auxiliary register are equal |

## Verification
Every result is due one cycle after its stimulus. The opcode and operands are sampled at a rising edge, and A, B and the equality flag all show the new state after that edge, because the flag is decoded from the registers with no extra stage. The driver applies each stimulus on a falling edge and queues the predicted state after the following rising edge. The monitor compares at the next falling edge, so each comparison falls exactly one register stage after its stimulus and away from any active edge.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_B_FROM_A   = 4'h0,
        OP_A_FROM_B   = 4'h1,
        OP_A_FROM_IMM = 4'h2,
        OP_A_FROM_MEM = 4'h3,
        OP_NOP4       = 4'h4,
        OP_NOP5       = 4'h5,
        OP_NOP6       = 4'h6,
        OP_NOP7       = 4'h7,
        OP_SHL        = 4'h8,
        OP_SHR        = 4'h9,
        OP_AND        = 4'hA,
        OP_OR         = 4'hB,
        OP_SUB        = 4'hC,
        OP_ADD        = 4'hD,
        OP_DEC        = 4'hE,
        OP_INC        = 4'hF
    } op_e;

    // Order follows the low three opcode bits of the arithmetic group
    typedef enum logic [2:0] {
        FN_SHL = 3'd0,
        FN_SHR = 3'd1,
        FN_AND = 3'd2,
        FN_OR  = 3'd3,
        FN_SUB = 3'd4,
        FN_ADD = 3'd5,
        FN_DEC = 3'd6,
        FN_INC = 3'd7
    } fn_e;

    typedef enum logic [2:0] {
        SRC_HOLD,
        SRC_AUX,
        SRC_IMM,
        SRC_MEM,
        SRC_ALU
    } src_e;

    typedef struct packed {
        src_e a_src;
        logic b_load;
        fn_e  fn;
    } ctl_t;

    function automatic ctl_t decode_op(input logic [OP_W-1:0] op, input logic strobe);
        ctl_t c;
        c.a_src  = SRC_HOLD;
        c.b_load = 1'b0;
        c.fn     = fn_e'(op[2:0]);
        if (strobe) begin
            if (op[3]) begin
                c.a_src = SRC_ALU;
            end else begin
                case (op)
                    OP_B_FROM_A:   c.b_load = 1'b1;
                    OP_A_FROM_B:   c.a_src  = SRC_AUX;
                    OP_A_FROM_IMM: c.a_src  = SRC_IMM;
                    OP_A_FROM_MEM: c.a_src  = SRC_MEM;
                    default:       c.a_src  = SRC_HOLD;
                endcase
            end
        end
        return c;
    endfunction

endpackage

// File: rtl/acc_op_decode.sv
module acc_op_decode
    import acc_alu_pkg::*;
(
    input  logic [OP_W-1:0] op_code,
    input  logic            wr_en,
    output ctl_t            ctl
);
    always_comb begin
        ctl = decode_op(op_code, wr_en);
    end
endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
    import acc_alu_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  fn_e          fn,
    output logic [W-1:0] res
);
    localparam logic [W-1:0] ONE = W'(1);

    always_comb begin
        unique case (fn)
            FN_SHL:  res = {opa[W-2:0], 1'b0};
            FN_SHR:  res = {1'b0, opa[W-1:1]};
            FN_AND:  res = opa & opb;
            FN_OR:   res = opa | opb;
            FN_SUB:  res = opa - opb;
            FN_ADD:  res = opa + opb;
            FN_DEC:  res = opa - ONE;
            FN_INC:  res = opa + ONE;
            default: res = opa;
        endcase
    end
endmodule

// File: rtl/acc_src_mux.sv
module acc_src_mux
    import acc_alu_pkg::*;
#(
    parameter int W = 4
) (
    input  src_e         sel,
    input  logic [W-1:0] cur_a,
    input  logic [W-1:0] aux,
    input  logic [W-1:0] imm,
    input  logic [W-1:0] mem,
    input  logic [W-1:0] alu_y,
    output logic [W-1:0] next_a
);
    always_comb begin
        case (sel)
            SRC_AUX: next_a = aux;
            SRC_IMM: next_a = imm;
            SRC_MEM: next_a = mem;
            SRC_ALU: next_a = alu_y;
            default: next_a = cur_a;
        endcase
    end
endmodule

// File: rtl/acc_regpair_alu.sv
module acc_regpair_alu
    import acc_alu_pkg::*;
#(
    parameter int W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [OP_W-1:0] op_code,
    input  logic [W-1:0]    imm_val,
    input  logic [W-1:0]    mem_rd,
    input  logic            wr_en,
    output logic [W-1:0]    acc_q,
    output logic [W-1:0]    aux_q,
    output logic            acc_eq_aux
);
    ctl_t         ctl;
    logic [W-1:0] alu_y;
    logic [W-1:0] acc_d;

    acc_op_decode u_dec (
        .op_code (op_code),
        .wr_en   (wr_en),
        .ctl     (ctl)
    );

    acc_alu_core #(.W(W)) u_alu (
        .opa (acc_q),
        .opb (aux_q),
        .fn  (ctl.fn),
        .res (alu_y)
    );

    acc_src_mux #(.W(W)) u_mux (
        .sel    (ctl.a_src),
        .cur_a  (acc_q),
        .aux    (aux_q),
        .imm    (imm_val),
        .mem    (mem_rd),
        .alu_y  (alu_y),
        .next_a (acc_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            aux_q <= '0;
        end else begin
            acc_q <= acc_d;
            if (ctl.b_load) aux_q <= acc_q;
        end
    end

    assign acc_eq_aux = (acc_q == aux_q);
endmodule

// File: rtl/acc_regpair_alu_chk.sv
module acc_regpair_alu_chk #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         rst,
    input logic [3:0]   op_code,
    input logic         wr_en,
    input logic [W-1:0] acc_q,
    input logic [W-1:0] aux_q,
    input logic         acc_eq_aux
);
    // R1
    rst_clears_chk: assert property (@(posedge clk)
        rst |=> (acc_q == '0 && aux_q == '0));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(acc_q) && $stable(aux_q)));

    // R3
    copy_to_aux_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && op_code == 4'h0) |=> (aux_q == $past(acc_q) && $stable(acc_q)));

    // R4
    copy_to_acc_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && op_code == 4'h1) |=> (acc_q == $past(aux_q)));

    // R8
    inc_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && op_code == 4'hF) |=> (acc_q == W'($past(acc_q) + 1'b1)));

    // R10
    reserved_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && op_code[3:2] == 2'b01) |=> ($stable(acc_q) && $stable(aux_q)));

    // R11
    eq_after_copy_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && op_code == 4'h0) |=> acc_eq_aux);

    // R12
    aux_only_by_copy_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && op_code != 4'h0) |=> $stable(aux_q));
endmodule

bind acc_regpair_alu acc_regpair_alu_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .op_code    (op_code),
    .wr_en      (wr_en),
    .acc_q      (acc_q),
    .aux_q      (aux_q),
    .acc_eq_aux (acc_eq_aux)
);

// File: tb/acc_regpair_alu_tb.sv
module acc_regpair_alu_tb;
    localparam int  W      = 4;
    localparam time CLK_PERIOD = 10ns;

    typedef struct {
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic         eq;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [3:0]   op_code = 4'h0;
    logic [W-1:0] imm_val = '0;
    logic [W-1:0] mem_rd = '0;
    logic         wr_en = 1'b0;
    logic [W-1:0] acc_q;
    logic [W-1:0] aux_q;
    logic         acc_eq_aux;

    exp_t         sb_q[$];
    int           checks = 0;
    int           errors = 0;
    logic [W-1:0] ma = '0;
    logic [W-1:0] mb = '0;
    bit           done = 1'b0;

    acc_regpair_alu #(.W(W)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .op_code    (op_code),
        .imm_val    (imm_val),
        .mem_rd     (mem_rd),
        .wr_en      (wr_en),
        .acc_q      (acc_q),
        .aux_q      (aux_q),
        .acc_eq_aux (acc_eq_aux)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Driver: apply on falling edge, predict state after the next rising edge
    task automatic drive(input logic r, input logic we, input logic [3:0] op,
                         input logic [W-1:0] iv, input logic [W-1:0] mv, input string tag);
        exp_t e;
        @(negedge clk);
        rst = r; wr_en = we; op_code = op; imm_val = iv; mem_rd = mv;
        @(posedge clk);
        if (r) begin
            ma = '0; mb = '0;
        end else if (we) begin
            case (op)
                4'h0: mb = ma;
                4'h1: ma = mb;
                4'h2: ma = iv;
                4'h3: ma = mv;
                4'h8: ma = {ma[W-2:0], 1'b0};
                4'h9: ma = {1'b0, ma[W-1:1]};
                4'hA: ma = ma & mb;
                4'hB: ma = ma | mb;
                4'hC: ma = W'(ma - mb);
                4'hD: ma = W'(ma + mb);
                4'hE: ma = W'(ma - 1);
                4'hF: ma = W'(ma + 1);
                default: ;
            endcase
        end
        e.a = ma; e.b = mb; e.eq = (ma == mb); e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: compare one cycle after each stimulus, on the falling edge
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (acc_q !== e.a || aux_q !== e.b || acc_eq_aux !== e.eq) begin
                errors++;
                $display("FAIL %s: acc=%h aux=%h eq=%b expected acc=%h aux=%h eq=%b",
                         e.tag, acc_q, aux_q, acc_eq_aux, e.a, e.b, e.eq);
            end
        end
    end

    initial begin
        drive(1, 0, 4'h0, 4'h0, 4'h0, "R1 reset");
        drive(0, 1, 4'h2, 4'h5, 4'h0, "R5 imm load");
        drive(0, 1, 4'h0, 4'h0, 4'h0, "R3 R11 copy A to B");
        drive(0, 1, 4'h2, 4'h3, 4'h0, "R5 R12 imm load");
        drive(0, 1, 4'hD, 4'h0, 4'h0, "R6 add");
        drive(0, 1, 4'hC, 4'h0, 4'h0, "R6 sub");
        drive(0, 1, 4'hC, 4'h0, 4'h0, "R6 sub wrap");
        drive(0, 1, 4'hA, 4'h0, 4'h0, "R7 and");
        drive(0, 1, 4'hB, 4'h0, 4'h0, "R7 R11 or");
        drive(0, 1, 4'hF, 4'h0, 4'h0, "R8 inc");
        drive(0, 1, 4'h2, 4'hF, 4'h0, "R5 imm F");
        drive(0, 1, 4'hF, 4'h0, 4'h0, "R8 inc wrap");
        drive(0, 1, 4'hE, 4'h0, 4'h0, "R8 dec wrap");
        drive(0, 1, 4'h8, 4'h0, 4'h0, "R9 shl");
        drive(0, 1, 4'h9, 4'h0, 4'h0, "R9 shr");
        drive(0, 1, 4'h2, 4'hB, 4'h0, "R5 imm B");
        drive(0, 1, 4'h8, 4'h0, 4'h0, "R9 shl msb drop");
        drive(0, 1, 4'h3, 4'h1, 4'h9, "R5 mem load");
        drive(0, 0, 4'hF, 4'h0, 4'h0, "R2 strobe low inc");
        drive(0, 0, 4'h2, 4'h7, 4'h0, "R2 strobe low imm");
        drive(0, 0, 4'h0, 4'h0, 4'h0, "R2 strobe low copy");
        for (int k = 4; k < 8; k++) drive(0, 1, 4'(k), 4'hE, 4'hD, "R10 reserved");
        drive(0, 1, 4'h1, 4'h0, 4'h0, "R4 R11 copy B to A");
        drive(0, 1, 4'h2, 4'h2, 4'h0, "R11 unequal");
        drive(1, 1, 4'hF, 4'h0, 4'h0, "R1 reset beats strobe");
        drive(0, 0, 4'h0, 4'h0, 4'h0, "R1 after reset");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule